// File: doc/BRIEF.md
# Multislope Integrating Converter Sequencer

This block is the digital side of a multislope integrating analog-to-digital converter. It drives three switch enables (signal input, positive reference, negative reference) and reads one comparator bit that tells whether the integrator output is above its reference level. A conversion has three parts. First comes an integration phase. During it the input is integrated while the comparator steers a pulse-width feedback pattern once per period. Next comes a rundown phase of fast, fast-opposite and slow slopes. Last comes a quiet hold phase, while an external converter samples the residual voltage.

The block reports raw counts only: the number of run-up periods with the positive-dominant pattern, the clock cycles with only the positive reference on, the cycles with only the negative reference on, and the cycles with both on. The two references are built slightly unequal in magnitude, so switching both on at once gives a small net current. That is the slow slope. A dual-slope mode integrates the input alone and then runs the same rundown. Scaling and combining the counts happens downstream.

Top module: `msadc_seq`

## Requirements
- R1: While reset is high and after it, all enables, `res_req`, `done` and `ovf` are low and every count reads zero.
- R2: A `start` pulse while idle makes `en_in` high for exactly `cfg_periods` × PERIOD consecutive cycles. The conversion settings are captured at that pulse.
- R3: Every run-up period of PERIOD cycles has the same layout. Slot 0 has both references off. Slots 1..M drive the minority polarity, with M = PERIOD/20. Slot M+1 has both off. The remaining PERIOD−M−2 slots drive the majority polarity. A synchronized comparator value of 1 makes the negative reference the majority polarity.
- R4: The comparator is sampled at the start and in the last slot of each period, and that value picks the pattern of the next period. `cnt_steps` counts the periods that used the positive-majority pattern.
- R5: A cycle with only one reference on is never directly followed by a cycle with only the other one on.
- R6: Rundown produces this output sequence. It starts with one all-off cycle. Then comes a fast slope toward the crossing: negative if the comparator reads 1, positive if it reads 0. It lasts until the synchronized comparator changes. Then comes one all-off cycle and the opposite fast slope, which lasts until the comparator returns. Then comes one all-off cycle and both references on, until the comparator changes again. Each slope stays on for SYNC_STAGES+1 cycles after the comparator input changes.
- R7: `cnt_pos`, `cnt_neg` and `cnt_fine` equal the number of conversion cycles with only `en_pos` high, only `en_neg` high, and both high.
- R8: After rundown all enables are low and `res_req` stays high until `res_ack`. Then `done` pulses for one cycle and `res_req` falls.
- R9: With `cfg_dual` = 1, no reference enable is high while `en_in` is high, and `cnt_steps` stays zero.
- R10: If rundown lasts `cfg_rd_max` cycles, counted from its first slope cycle, the block goes to hold and raises `ovf`. `ovf` stays low on a normal conversion.
- R11: A `start` pulse during a conversion is ignored.
- R12: A count that reaches all ones stays there, and a further increment attempt raises `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle conversion request |
| cfg_dual | input | 1 | 1 = dual-slope mode |
| cfg_periods | input | PW | Number of run-up periods (at least 1) |
| cfg_rd_max | input | RW | Rundown cycle limit |
| cmp_in | input | 1 | Comparator, 1 = integrator above reference level |
| res_ack | input | 1 | Residual sample taken |
| en_in | output | 1 | Input switch enable |
| en_pos | output | 1 | Positive reference enable |
| en_neg | output | 1 | Negative reference enable |
| res_req | output | 1 | Hold phase, residual may be sampled |
| done | output | 1 | One-cycle pulse, counts valid |
| ovf | output | 1 | Rundown limit or count saturation |
| cnt_steps | output | PW | Positive-majority run-up periods |
| cnt_pos | output | CW | Positive-only cycles |
| cnt_neg | output | CW | Negative-only cycles |
| cnt_fine | output | CW | Both-on (slow slope) cycles |

## Verification
The bench builds the block with PERIOD = 40, which gives a 2-cycle minority and a 36-cycle majority, so every pattern count has a closed-form expected value. It uses CW = 10, so a 30-period conversion pushes the negative count past 1023 and reaches saturation. It uses SYNC_STAGES = 2, so each rundown slope lasts exactly 8 cycles when the modelled comparator flips 5 cycles into the slope. A rundown limit of 50 with a stuck comparator exercises the overflow exit in both run-up polarities.

// File: rtl/msadc_pkg.sv
package msadc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RUN, ST_GAP1, ST_FAST1, ST_GAP2,
    ST_FAST2, ST_GAP3, ST_SLOW, ST_HOLD
  } phase_t;
endpackage

// File: rtl/msadc_sync.sv
module msadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk)
        if (rst) sh[0] <= 1'b0;
        else     sh[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk)
        if (rst) sh[g] <= 1'b0;
        else     sh[g] <= sh[g-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/msadc_satcnt.sv
module msadc_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         full
);
  assign full = &q;

  always_ff @(posedge clk)
    if (rst || clr)       q <= '0;
    else if (inc && !full) q <= q + W'(1);

  // R12
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !clr) |=> full);
endmodule

// File: rtl/msadc_runup.sv
module msadc_runup #(
  parameter int PERIOD = 500,
  parameter int PW     = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          begin_i,
  input  logic          active,
  input  logic          cmp_s,
  input  logic [PW-1:0] n_periods,
  output logic          drive_pos,
  output logic          drive_neg,
  output logic          period_head,
  output logic          final_slot,
  output logic          dec
);
  localparam int SW    = $clog2(PERIOD);
  localparam int MINOR = (PERIOD / 20 < 1) ? 1 : PERIOD / 20;
  localparam logic [SW-1:0] LAST    = SW'(PERIOD - 1);
  localparam logic [SW-1:0] MIN_END = SW'(MINOR);
  localparam logic [SW-1:0] MAJ_BEG = SW'(MINOR + 2);

  logic [SW-1:0] slot;
  logic [PW-1:0] per;
  logic minor, major, end_period;

  assign end_period = (slot == LAST);

  always_ff @(posedge clk)
    if (rst) begin
      slot <= '0;
      per  <= '0;
      dec  <= 1'b0;
    end else if (begin_i) begin
      slot <= '0;
      per  <= '0;
      dec  <= cmp_s;
    end else if (active) begin
      if (end_period) begin
        slot <= '0;
        per  <= per + PW'(1);
        dec  <= cmp_s;
      end else begin
        slot <= slot + SW'(1);
      end
    end

  assign minor       = (slot != '0) && (slot <= MIN_END);
  assign major       = (slot >= MAJ_BEG);
  assign drive_pos   = active && (dec ? minor : major);
  assign drive_neg   = active && (dec ? major : minor);
  assign period_head = active && (slot == '0);
  assign final_slot  = active && end_period && (per == n_periods - PW'(1));

  // R4
  pattern_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && slot != '0) |-> $stable(dec));
endmodule

// File: rtl/msadc_seq.sv
module msadc_seq
  import msadc_pkg::*;
#(
  parameter int PERIOD      = 500,
  parameter int PW          = 16,
  parameter int RW          = 16,
  parameter int CW          = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cfg_dual,
  input  logic [PW-1:0] cfg_periods,
  input  logic [RW-1:0] cfg_rd_max,
  input  logic          cmp_in,
  input  logic          res_ack,
  output logic          en_in,
  output logic          en_pos,
  output logic          en_neg,
  output logic          res_req,
  output logic          done,
  output logic          ovf,
  output logic [PW-1:0] cnt_steps,
  output logic [CW-1:0] cnt_pos,
  output logic [CW-1:0] cnt_neg,
  output logic [CW-1:0] cnt_fine
);
  localparam int NCNT = 3;

  phase_t        state;
  logic          dual_q, dir, cmp_s, accept, rundown, limit;
  logic [PW-1:0] n_q;
  logic [RW-1:0] rdmax_q, rd_cnt;
  logic          ru_pos, ru_neg, head, fin, dec;
  logic [NCNT-1:0] inc, full;
  logic [CW-1:0] cnt_q [NCNT];
  logic          inc_s, full_s;

  msadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cmp_in), .q(cmp_s));

  msadc_runup #(.PERIOD(PERIOD), .PW(PW)) u_runup (
    .clk(clk), .rst(rst), .begin_i(accept), .active(state == ST_RUN),
    .cmp_s(cmp_s), .n_periods(n_q), .drive_pos(ru_pos), .drive_neg(ru_neg),
    .period_head(head), .final_slot(fin), .dec(dec));

  assign accept  = (state == ST_IDLE) && start;
  assign rundown = state inside {ST_FAST1, ST_GAP2, ST_FAST2, ST_GAP3, ST_SLOW};
  assign limit   = rundown && (rd_cnt >= rdmax_q - RW'(1));

  // phase sequencing
  always_ff @(posedge clk)
    if (rst) begin
      state   <= ST_IDLE;
      dual_q  <= 1'b0;
      n_q     <= '0;
      rdmax_q <= '0;
      rd_cnt  <= '0;
      dir     <= 1'b0;
    end else begin
      if (rundown) rd_cnt <= rd_cnt + RW'(1);
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          dual_q  <= cfg_dual;
          n_q     <= cfg_periods;
          rdmax_q <= cfg_rd_max;
        end
        ST_RUN:  if (fin) state <= ST_GAP1;
        ST_GAP1: begin
          dir    <= cmp_s;
          rd_cnt <= '0;
          state  <= ST_FAST1;
        end
        ST_FAST1: if (limit) state <= ST_HOLD;
                  else if (cmp_s != dir) state <= ST_GAP2;
        ST_GAP2:  if (limit) state <= ST_HOLD;
                  else state <= ST_FAST2;
        ST_FAST2: if (limit) state <= ST_HOLD;
                  else if (cmp_s == dir) state <= ST_GAP3;
        ST_GAP3:  if (limit) state <= ST_HOLD;
                  else state <= ST_SLOW;
        ST_SLOW:  if (limit || cmp_s != dir) state <= ST_HOLD;
        ST_HOLD:  if (res_req && res_ack) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end

  // registered switch and handshake outputs
  always_ff @(posedge clk)
    if (rst) begin
      en_in   <= 1'b0;
      en_pos  <= 1'b0;
      en_neg  <= 1'b0;
      res_req <= 1'b0;
      done    <= 1'b0;
    end else begin
      en_in   <= (state == ST_RUN);
      en_pos  <= (state == ST_RUN && !dual_q && ru_pos) ||
                 (state == ST_FAST1 && !dir) || (state == ST_FAST2 && dir) ||
                 (state == ST_SLOW);
      en_neg  <= (state == ST_RUN && !dual_q && ru_neg) ||
                 (state == ST_FAST1 && dir) || (state == ST_FAST2 && !dir) ||
                 (state == ST_SLOW);
      res_req <= (state == ST_HOLD) && !(res_req && res_ack);
      done    <= (state == ST_HOLD) && res_req && res_ack;
    end

  // cycle counters taken from the registered enables
  assign inc[0] = en_pos && !en_neg;
  assign inc[1] = !en_pos && en_neg;
  assign inc[2] = en_pos && en_neg;

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    msadc_satcnt #(.W(CW)) u_cnt (
      .clk(clk), .rst(rst), .clr(accept), .inc(inc[k]),
      .q(cnt_q[k]), .full(full[k]));
  end

  assign inc_s = head && !dual_q && !dec;
  msadc_satcnt #(.W(PW)) u_steps (
    .clk(clk), .rst(rst), .clr(accept), .inc(inc_s),
    .q(cnt_steps), .full(full_s));

  assign cnt_pos  = cnt_q[0];
  assign cnt_neg  = cnt_q[1];
  assign cnt_fine = cnt_q[2];

  always_ff @(posedge clk)
    if (rst || accept) ovf <= 1'b0;
    else if (limit || |(inc & full) || (inc_s && full_s)) ovf <= 1'b1;

  // R5
  bbm_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (en_pos && !en_neg) |=> !(en_neg && !en_pos));
  // R5
  bbm_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (en_neg && !en_pos) |=> !(en_pos && !en_neg));
  // R9
  dual_refs_chk: assert property (@(posedge clk) disable iff (rst)
    (dual_q && en_in) |-> !(en_pos || en_neg));
  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    res_req |-> !(en_in || en_pos || en_neg));
  // R8
  req_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (res_req && !res_ack) |=> res_req);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !accept) |=> ovf);
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && start && !fin) |=> (state == ST_RUN));
endmodule

// File: tb/msadc_seq_test.sv
module msadc_seq_test;
  localparam int P    = 40;
  localparam int M    = 2;
  localparam int MAJ  = P - M - 2;
  localparam int SYN  = 2;
  localparam int FLIP = 5;
  localparam int SLEN = FLIP + SYN + 1;
  localparam int PW = 16, RW = 16, CW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cfg_dual = 1'b0;
  logic [PW-1:0] cfg_periods = '0;
  logic [RW-1:0] cfg_rd_max = '0;
  logic cmp_in = 1'b0;
  logic res_ack = 1'b0;
  logic en_in, en_pos, en_neg, res_req, done, ovf;
  logic [PW-1:0] cnt_steps;
  logic [CW-1:0] cnt_pos, cnt_neg, cnt_fine;

  always #10 clk = ~clk;

  msadc_seq #(.PERIOD(P), .PW(PW), .RW(RW), .CW(CW), .SYNC_STAGES(SYN)) uut (
    .clk(clk), .rst(rst), .start(start), .cfg_dual(cfg_dual),
    .cfg_periods(cfg_periods), .cfg_rd_max(cfg_rd_max), .cmp_in(cmp_in),
    .res_ack(res_ack), .en_in(en_in), .en_pos(en_pos), .en_neg(en_neg),
    .res_req(res_req), .done(done), .ovf(ovf), .cnt_steps(cnt_steps),
    .cnt_pos(cnt_pos), .cnt_neg(cnt_neg), .cnt_fine(cnt_fine));

  int tests = 0, fails = 0;
  // control written by the stimulus process only
  int  load_req = 0, clr_req = 0;
  logic cmp_val = 1'b0;
  bit  script = 1'b0;
  // monitor state written by the monitor only
  int load_seen = 0, clr_seen = 0;
  int c_in, c_pos, c_neg, c_both, c_refin, c_done, c_reqbad, c_req, run, nseq, req_cnt;
  bit seen_in;
  logic [1:0] combo, prev;
  logic [1:0] seq_c [10];
  int seq_l [10];

  always @(negedge clk) begin
    if (load_req != load_seen) begin cmp_in = cmp_val; load_seen = load_req; end
    if (clr_req != clr_seen) begin
      clr_seen = clr_req;
      c_in = 0; c_pos = 0; c_neg = 0; c_both = 0; c_refin = 0; c_done = 0;
      c_reqbad = 0; c_req = 0; run = 0; nseq = 0; req_cnt = 0; seen_in = 1'b0;
      prev = 2'b00;
    end
    combo = {en_pos, en_neg};
    if (en_in) c_in++;
    if (combo == 2'b10) c_pos++;
    if (combo == 2'b01) c_neg++;
    if (combo == 2'b11) c_both++;
    if (en_in && combo != 2'b00) c_refin++;
    if (done) c_done++;
    if (res_req) c_req++;
    if (res_req && (en_in || combo != 2'b00)) c_reqbad++;
    if (combo == prev) run++; else run = 1;
    prev = combo;
    if (en_in) seen_in = 1'b1;
    else if (seen_in) begin
      if (nseq > 0 && seq_c[nseq-1] == combo) seq_l[nseq-1]++;
      else if (nseq < 10) begin seq_c[nseq] = combo; seq_l[nseq] = 1; nseq++; end
      if (script && combo != 2'b00 && run == FLIP) cmp_in = ~cmp_in;
    end
    if (res_req && !res_ack) begin
      req_cnt++;
      if (req_cnt >= 3) res_ack = 1'b1;
    end
    if (done) begin res_ack = 1'b0; req_cnt = 0; end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_conv(input bit dual, input int n, input int rdmax,
                          input bit scr, input logic c0, input int extra_at);
    @(posedge clk);
    cfg_dual = dual; cfg_periods = PW'(n); cfg_rd_max = RW'(rdmax);
    script = scr; cmp_val = c0; load_req++; clr_req++;
    repeat (4) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (extra_at > 0) begin
      repeat (extra_at) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    for (int t = 0; t < 20000; t++) begin
      @(posedge clk);
      if (c_done != 0) break;
    end
    chk("R8", "done seen", c_done, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "en_in", en_in, 0);
    chk("R1", "en_pos|en_neg", en_pos | en_neg, 0);
    chk("R1", "res_req|done", res_req | done, 0);
    chk("R1", "ovf", ovf, 0);
    chk("R1", "counts", cnt_pos + cnt_neg + cnt_fine + cnt_steps, 0);
  endtask

  task automatic t_stuck(input logic c0);
    run_conv(1'b0, 4, 50, 1'b0, c0, 0);
    chk("R2", "input cycles", c_in, 4 * P);
    chk("R3", "positive-only", cnt_pos, c0 ? 4 * M : 4 * MAJ + 50);
    chk("R3", "negative-only", cnt_neg, c0 ? 4 * MAJ + 50 : 4 * M);
    chk("R4", "steps", cnt_steps, c0 ? 0 : 4);
    chk("R10", "ovf on stuck comparator", ovf, 1);
    chk("R10", "no slow slope", cnt_fine, 0);
    chk("R7", "pos vs observed", cnt_pos, c_pos);
    chk("R7", "neg vs observed", cnt_neg, c_neg);
  endtask

  task automatic t_rundown(input logic c0);
    logic [1:0] a, b;
    a = c0 ? 2'b01 : 2'b10;
    b = c0 ? 2'b10 : 2'b01;
    run_conv(1'b0, 3, 1000, 1'b1, c0, 0);
    chk("R6", "segments", nseq, 7);
    chk("R6", "seg0 off", seq_c[0], 2'b00);
    chk("R6", "seg0 len", seq_l[0], 1);
    chk("R6", "fast slope", seq_c[1], a);
    chk("R6", "fast len", seq_l[1], SLEN);
    chk("R6", "gap len", seq_l[2], 1);
    chk("R6", "opposite slope", seq_c[3], b);
    chk("R6", "opposite len", seq_l[3], SLEN);
    chk("R6", "gap2 len", seq_l[4], 1);
    chk("R6", "slow slope", seq_c[5], 2'b11);
    chk("R6", "slow len", seq_l[5], SLEN);
    chk("R6", "hold off", seq_c[6], 2'b00);
    chk("R4", "steps", cnt_steps, c0 ? 0 : 3);
    chk("R7", "pos", cnt_pos, c0 ? 3 * M + SLEN : 3 * MAJ + SLEN);
    chk("R7", "neg", cnt_neg, c0 ? 3 * MAJ + SLEN : 3 * M + SLEN);
    chk("R7", "fine", cnt_fine, c_both);
    chk("R10", "no ovf", ovf, 0);
    chk("R8", "quiet hold", c_reqbad, 0);
    chk("R8", "req held until ack", c_req, 3);
    chk("R8", "req dropped", res_req, 0);
  endtask

  task automatic t_dual;
    run_conv(1'b1, 3, 1000, 1'b1, 1'b1, 0);
    chk("R9", "refs during input", c_refin, 0);
    chk("R9", "steps", cnt_steps, 0);
    chk("R2", "input cycles", c_in, 3 * P);
    chk("R9", "pos", cnt_pos, SLEN);
    chk("R9", "fine", cnt_fine, SLEN);
  endtask

  task automatic t_busy;
    run_conv(1'b0, 3, 1000, 1'b1, 1'b1, 50);
    repeat (200) @(posedge clk);
    chk("R11", "input cycles", c_in, 3 * P);
    chk("R11", "done count", c_done, 1);
    chk("R11", "neg count", cnt_neg, 3 * MAJ + SLEN);
  endtask

  task automatic t_sat;
    run_conv(1'b0, 30, 1000, 1'b1, 1'b1, 0);
    chk("R12", "neg saturated", cnt_neg, (1 << CW) - 1);
    chk("R12", "observed neg", c_neg, 30 * MAJ + SLEN);
    chk("R12", "ovf", ovf, 1);
    chk("R12", "pos", cnt_pos, 30 * M + SLEN);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_stuck(1'b1);
    t_stuck(1'b0);
    t_rundown(1'b1);
    t_rundown(1'b0);
    t_dual();
    t_busy();
    t_sat();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R2 watchdog: got hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule